// File: doc/BRIEF.md
# Strip Hit Address Encoder With Neighbor

This block reduces the per-crossing trigger bits of a 128-strip front end to a short list of hit addresses and sends that list out on eight serial lanes. The list is built from the lowest channel upward. Each entry names one hit channel and carries a flag that says whether the channel just above it also fired. A channel that was already flagged this way is not listed again. At most eight entries leave per crossing, one per lane; any hits beyond that are dropped.

A fast bit clock runs ten times per crossing. Each lane shifts out one 10-bit slot per crossing, most significant bit first. A separate sync output pulses during the first bit period of every crossing. A mode input selects between single-strip resolution and paired resolution. In paired mode, neighbouring strips are ORed into 64 groups before addresses are chosen. The hit vector and the mode are sampled once per crossing, and the lanes then carry the result during the following crossing.

Top module: `strip_hit_lane_encoder`

## Requirements
- R1: `sync_o` is high for exactly one bit clock, the first bit period of each crossing, and is low for the other 9 bit periods. Crossings are 10 bit clocks long and follow one another with no gap.
- R2: `hits_in` and `pair_mode` are sampled at the rising edge that ends the last bit period of a crossing. The slots built from them are shifted out during the next crossing. Values present at other edges have no effect.
- R3: In single-strip mode (`pair_mode`=0) a slot is sent MSB first. Bit 9 is the valid bit, bits 8:2 hold the 7-bit channel number, bit 1 is the neighbour flag and bit 0 is 0.
- R4: Entries are listed in ascending address order, and lane k carries the k-th entry. A lane with no entry sends an all-zero slot, so valid slots always occupy the lowest-numbered lanes.
- R5: The neighbour flag of an entry is 1 exactly when address+1 is also hit. A channel covered by such a flag is not listed as an entry of its own. For example, a run of hits at 10, 11 and 12 yields entries 10 (flag 1) and 12 (flag 0).
- R6: In paired mode (`pair_mode`=1) group g is hit when strip 2g or strip 2g+1 is hit. The slot holds bit 9 valid, bits 8:3 the 6-bit group number, bit 2 the neighbour flag and bits 1:0 zero.
- R7: The top address (channel 127, or group 63 in paired mode) always sends a neighbour flag of 0.
- R8: No more than 8 entries are sent per crossing. When more would be produced, the 8 lowest are kept and the rest are lost.
- R9: A crossing sampled with no hit sends a valid bit of 0, and in fact all-zero slots, on every lane.
- R10: During reset every lane is low and `sync_o` is high. The crossing that begins when reset ends carries all-zero slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, ten periods per crossing |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pair_mode | input | 1 | 0: single-strip addresses, 1: paired-strip groups |
| hits_in | input | 128 | Trigger bit per strip for the current crossing |
| lane_o | output | 8 | Serial data lanes, one slot per lane per crossing |
| sync_o | output | 1 | High in the first bit period of each crossing |

## Verification
Two functions can fall in the same clock: loading a new set of slots, and shifting out the last bit of the previous crossing's slots. Both happen at the edge that ends bit period 9, where the sync pulse and the next valid bits also appear. The bench provokes this by changing `hits_in` and `pair_mode` at many phases inside a crossing, including the cycle right before the sampling edge. A behavioural model samples the inputs at the same edge and compares every lane bit and the sync level on every clock. A stale slot, a lost final bit, or a sample taken one edge early or late therefore shows up as a mismatch on the first bit period of the following crossing.

// File: rtl/shl_pkg.sv
package shl_pkg;
  localparam int unsigned CH_COUNT   = 128;
  localparam int unsigned LANE_COUNT = 8;
  localparam int unsigned ADDR_BITS  = $clog2(CH_COUNT);
  localparam int unsigned SLOT_BITS  = ADDR_BITS + 3;
endpackage

// File: rtl/shl_group_fold.sv
module shl_group_fold #(
  parameter int unsigned N = 128
) (
  input  logic [N-1:0] hits,
  input  logic         pair_mode,
  output logic [N-1:0] vec
);
  localparam int unsigned HALF = N / 2;

  logic [HALF-1:0] folded;

  genvar g;
  generate
    for (g = 0; g < HALF; g++) begin : g_fold
      assign folded[g] = hits[2*g] | hits[2*g+1];
    end
  endgenerate

  always_comb begin
    if (pair_mode) vec = {{(N-HALF){1'b0}}, folded};
    else           vec = hits;
  end
endmodule

// File: rtl/shl_head_mark.sv
module shl_head_mark #(
  parameter int unsigned N = 128
) (
  input  logic [N-1:0] vec,
  output logic [N-1:0] head,
  output logic [N-1:0] nbr
);
  // A hit starts an entry unless the hit below it started one (it is then
  // carried as that entry's neighbour flag).
  always_comb begin
    head[0] = vec[0];
    for (int i = 1; i < N; i++) begin
      head[i] = vec[i] & ~head[i-1];
    end
  end

  always_comb begin
    nbr = {1'b0, vec[N-1:1]};
  end
endmodule

// File: rtl/shl_entry_pick.sv
module shl_entry_pick #(
  parameter int unsigned N     = 128,
  parameter int unsigned LANES = 8,
  parameter int unsigned AW    = 7
) (
  input  logic [N-1:0]           head,
  input  logic [N-1:0]           nbr,
  output logic [LANES-1:0]       ent_valid,
  output logic [LANES-1:0][AW-1:0] ent_addr,
  output logic [LANES-1:0]       ent_nb
);
  logic [LANES:0][N-1:0] rem;

  assign rem[0] = head;

  genvar s;
  generate
    for (s = 0; s < LANES; s++) begin : g_stage
      logic [N-1:0]  lsb;
      logic [AW-1:0] enc;

      assign lsb        = rem[s] & (~rem[s] + 1'b1);
      assign rem[s+1]   = rem[s] & ~lsb;
      assign ent_valid[s] = |rem[s];
      assign ent_nb[s]    = |(lsb & nbr);

      always_comb begin
        enc = '0;
        for (int i = 0; i < N; i++) begin
          if (lsb[i]) enc = enc | AW'(i);
        end
      end

      assign ent_addr[s] = enc;
    end
  endgenerate
endmodule

// File: rtl/shl_lane_serializer.sv
module shl_lane_serializer #(
  parameter int unsigned LANES = 8,
  parameter int unsigned SW    = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [LANES-1:0][SW-1:0] slots,
  output logic [LANES-1:0]         lane_o
);
  logic [LANES-1:0][SW-1:0] sh_q, sh_d;

  genvar k;
  generate
    for (k = 0; k < LANES; k++) begin : g_lane
      always_comb begin
        if (load) sh_d[k] = slots[k];
        else      sh_d[k] = {sh_q[k][SW-2:0], 1'b0};
      end
      assign lane_o[k] = sh_q[k][SW-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end
endmodule

// File: rtl/strip_hit_lane_encoder.sv
module strip_hit_lane_encoder #(
  parameter int unsigned NUM_CH = shl_pkg::CH_COUNT,
  parameter int unsigned LANES  = shl_pkg::LANE_COUNT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pair_mode,
  input  logic [NUM_CH-1:0] hits_in,
  output logic [LANES-1:0]  lane_o,
  output logic              sync_o
);
  localparam int unsigned AW     = $clog2(NUM_CH);
  localparam int unsigned SLOT_W = AW + 3;
  localparam int unsigned CNT_W  = $clog2(SLOT_W);
  localparam int unsigned PAD_S  = SLOT_W - AW - 2;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SLOT_W - 1);

  // reset: asynchronous assert, synchronous release
  logic rst_s1, rst_n_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_n_sync <= rst_s1;
    end
  end

  // bit-period counter inside a crossing
  logic [CNT_W-1:0] bit_cnt_q, bit_cnt_d;
  logic             load_slot;

  assign load_slot = (bit_cnt_q == LAST_BIT);

  always_comb begin
    if (load_slot) bit_cnt_d = '0;
    else           bit_cnt_d = bit_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) bit_cnt_q <= '0;
    else             bit_cnt_q <= bit_cnt_d;
  end

  assign sync_o = (bit_cnt_q == '0);

  // address selection
  logic [NUM_CH-1:0] vec, head, nbr;
  logic [LANES-1:0]          ent_valid, ent_nb;
  logic [LANES-1:0][AW-1:0]  ent_addr;

  shl_group_fold #(.N(NUM_CH)) u_fold (
    .hits      (hits_in),
    .pair_mode (pair_mode),
    .vec       (vec)
  );

  shl_head_mark #(.N(NUM_CH)) u_head (
    .vec  (vec),
    .head (head),
    .nbr  (nbr)
  );

  shl_entry_pick #(.N(NUM_CH), .LANES(LANES), .AW(AW)) u_pick (
    .head      (head),
    .nbr       (nbr),
    .ent_valid (ent_valid),
    .ent_addr  (ent_addr),
    .ent_nb    (ent_nb)
  );

  // slot formatting
  logic [LANES-1:0][SLOT_W-1:0] slots;

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      if (!ent_valid[k])
        slots[k] = '0;
      else if (pair_mode)
        slots[k] = {1'b1, ent_addr[k][AW-2:0], ent_nb[k], {(PAD_S+1){1'b0}}};
      else
        slots[k] = {1'b1, ent_addr[k], ent_nb[k], {PAD_S{1'b0}}};
    end
  end

  shl_lane_serializer #(.LANES(LANES), .SW(SLOT_W)) u_ser (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .load   (load_slot),
    .slots  (slots),
    .lane_o (lane_o)
  );
endmodule

// File: rtl/shl_checker.sv
module shl_checker #(
  parameter int unsigned N     = 128,
  parameter int unsigned LANES = 8,
  parameter int unsigned SW    = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_o,
  input logic [LANES-1:0] lane_o,
  input logic [N-1:0]     hits_in,
  input logic             load
);
  localparam int unsigned GW = $clog2(SW) + 1;

  logic [GW-1:0]    gap_q;
  logic             seen_q;
  logic [LANES-1:0] idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
      idle_q <= '0;
    end else begin
      if (sync_o) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
        idle_q <= ~lane_o;
      end else begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  p_sync_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |=> !sync_o);

  p_sync_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_o && seen_q) |-> (gap_q == GW'(SW - 1)));

  p_empty_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (hits_in == '0)) |=> (sync_o && (lane_o == '0)));

  genvar k;
  generate
    for (k = 0; k < LANES; k++) begin : g_chk
      p_idle_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_o && seen_q && idle_q[k]) |-> !lane_o[k]);
      if (k > 0) begin : g_pack
        p_lane_pack_r4: assert property (@(posedge clk) disable iff (!rst_n)
          (sync_o && lane_o[k]) |-> lane_o[k-1]);
      end
    end
  endgenerate
endmodule

bind strip_hit_lane_encoder shl_checker #(
  .N(NUM_CH), .LANES(LANES), .SW(SLOT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n_sync),
  .sync_o  (sync_o),
  .lane_o  (lane_o),
  .hits_in (hits_in),
  .load    (load_slot)
);

// File: tb/tb_strip_hit_lane_encoder.sv
module tb_strip_hit_lane_encoder;
  localparam int NCH = 128;
  localparam int NL  = 8;
  localparam int SW  = 10;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           pair_mode;
  logic [NCH-1:0] hits_in;
  logic [NL-1:0]  lane_o;
  logic           sync_o;

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  bit    cmp_en = 0;
  string tag    = "R10";

  logic [SW-1:0] exp_slot [NL];
  int ph  = 0;
  int rel = 0;

  always #10 clk = ~clk;

  strip_hit_lane_encoder dut (
    .clk(clk), .rst_n(rst_n), .pair_mode(pair_mode),
    .hits_in(hits_in), .lane_o(lane_o), .sync_o(sync_o)
  );

  // behavioural list builder following R3, R5..R8
  task automatic build(input logic [NCH-1:0] h, input logic pm);
    logic [NCH-1:0] v;
    int lim, n, i;
    logic nb;
    v = '0;
    lim = pm ? NCH/2 : NCH;
    for (int j = 0; j < lim; j++) v[j] = pm ? (h[2*j] | h[2*j+1]) : h[j];
    for (int k = 0; k < NL; k++) exp_slot[k] = '0;
    n = 0; i = 0;
    while (i < lim && n < NL) begin
      if (v[i]) begin
        nb = (i + 1 < lim) ? v[i+1] : 1'b0;
        if (pm) exp_slot[n] = {1'b1, i[5:0], nb, 2'b00};
        else    exp_slot[n] = {1'b1, i[6:0], nb, 1'b0};
        n++;
        i = i + (nb ? 2 : 1);
      end else begin
        i++;
      end
    end
  endtask

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; rel = 0;
      for (int k = 0; k < NL; k++) exp_slot[k] = '0;
    end else if (rel < 2) begin
      rel++;
    end else if (ph == SW - 1) begin
      build(hits_in, pair_mode);
      ph = 0;
    end else begin
      ph++;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      logic [NL-1:0] el;
      logic es;
      for (int k = 0; k < NL; k++) el[k] = exp_slot[k][SW-1-ph];
      es = (ph == 0);
      checks++;
      if (lane_o !== el || sync_o !== es) begin
        fails++;
        $display("FAIL %s phase=%0d lanes=%b sync=%b expected lanes=%b sync=%b",
                 tag, ph, lane_o, sync_o, el, es);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apply(input string t, input logic pm, input logic [NCH-1:0] h, input int n);
    tag = t;
    pair_mode = pm;
    hits_in = h;
    hold(n);
  endtask

  function automatic logic [NCH-1:0] bits_at(input int a, input int b, input int c);
    logic [NCH-1:0] r;
    r = '0;
    if (a >= 0) r[a] = 1'b1;
    if (b >= 0) r[b] = 1'b1;
    if (c >= 0) r[c] = 1'b1;
    return r;
  endfunction

  initial begin
    logic [NCH-1:0] spread;
    rst_n = 1'b0;
    pair_mode = 1'b0;
    hits_in = '0;
    hold(3);
    // R10: reset state
    checks++;
    if (lane_o !== '0 || sync_o !== 1'b1) begin
      fails++;
      $display("FAIL R10 reset lanes=%b sync=%b expected lanes=%b sync=1", lane_o, sync_o, {NL{1'b0}});
    end
    hits_in = bits_at(3, -1, -1);
    rst_n = 1'b1;
    cmp_en = 1;
    hold(5);                                      // R10 first crossing after reset
    apply("R9",  1'b0, '0, 30);
    apply("R3",  1'b0, bits_at(0, -1, -1), 30);
    apply("R3",  1'b0, bits_at(100, -1, -1), 30);
    apply("R5",  1'b0, bits_at(5, 6, -1), 30);
    apply("R5",  1'b0, bits_at(10, 11, 12), 30);
    apply("R7",  1'b0, bits_at(126, 127, -1), 30);
    apply("R7",  1'b0, bits_at(127, -1, -1), 30);
    spread = '0;
    for (int i = 0; i < 12; i++) spread[4*i] = 1'b1;
    apply("R8",  1'b0, spread, 30);
    apply("R8",  1'b0, '1, 30);
    apply("R6",  1'b1, bits_at(0, 3, -1), 30);
    apply("R6",  1'b1, bits_at(2, 90, -1), 30);
    apply("R7",  1'b1, bits_at(126, -1, -1), 30);
    apply("R7",  1'b1, bits_at(124, 127, -1), 30);
    apply("R8",  1'b1, '1, 30);
    apply("R9",  1'b1, '0, 30);
    // R2: inputs change at every phase of the crossing
    for (int i = 0; i < 40; i++) begin
      logic [NCH-1:0] r;
      for (int w = 0; w < NCH / 32; w++)
        r[32*w +: 32] = $urandom() & $urandom() & $urandom();
      apply("R2", ($urandom() % 2) == 1, r, 7 + (i % 5));
    end
    apply("R4",  1'b0, bits_at(20, 60, 61), 30);
    hits_in = '0;
    hold(25);
    cmp_en = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule